// File: doc/BRIEF.md
# Complementary Phase Output Comparator

This block drives one phase of a three-phase inverter bridge. It compares a single duty compare value against two triangle counters that run in lockstep. Counter A sits one dead time above counter B. A match on counter A moves the antiphase output and a match on counter B moves the positive-phase output. Because the same compare value reaches the two counters a dead time apart, the two outputs never overlap and a gap of one dead time separates them. No separate delay timer is needed for this gap.

Each output holds an internal active/inactive state. The state is mapped to a pin level by a per-pin polarity bit and gated by a per-pin output enable. A compare value of zero, or a value at or above the counter upper limit, saturates the phase to constant levels. Three instances serve a three-phase bridge. The counters and the buffered loading of the compare value live outside this block.

Top module: `comp_phase_out`

## Requirements
- R1: When counter A equals the compare value while its direction flag is 0 (counting up), the antiphase state becomes inactive one clock later.
- R2: When counter B equals the compare value while its direction flag is 0 (counting up), the positive-phase state becomes active one clock later.
- R3: When counter A equals the compare value while its direction flag is 1 (counting down), the antiphase state becomes active one clock later.
- R4: When counter B equals the compare value while its direction flag is 1 (counting down), the positive-phase state becomes inactive one clock later.
- R5: A compare value of zero forces, one clock later, the positive-phase state active and the antiphase state inactive, whatever the counters do.
- R6: A nonzero compare value at or above the upper limit forces, one clock later, the positive-phase state inactive and the antiphase state active, whatever the counters do.
- R7: Outside R1 to R6, each state holds its value.
- R8: A pin shows its polarity bit when its state is active and the inverse of that bit when inactive, so polarity 0 means active-low. After reset both states are inactive, so with polarity 0 both pins are high.
- R9: A cleared output enable holds its pin at the inactive level. The state behind the pin keeps following R1 to R7.
- R10: With counter A equal to counter B plus the dead time, both counting together, and a compare value in range, the two outputs are never active together. The positive phase turns on exactly a dead time after the antiphase turns off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_a | input | W | Counter A (leads by the dead time) |
| cnt_b | input | W | Counter B |
| a_down | input | 1 | 1 when counter A counts down |
| b_down | input | 1 | 1 when counter B counts down |
| cmp_val | input | W | Duty compare value |
| upper_lim | input | W | Counter A upper limit |
| pol_pos | input | 1 | Active level of the positive-phase pin |
| pol_neg | input | 1 | Active level of the antiphase pin |
| oe_pos | input | 1 | Positive-phase pin enable |
| oe_neg | input | 1 | Antiphase pin enable |
| pos_out | output | 1 | Positive-phase pin |
| neg_out | output | 1 | Antiphase pin |

## Verification
The bench builds the block with W set to 8. It drives a carrier with a half period of 20 clocks and a dead time of 3, so the upper limit is 23. With this short carrier, every match, both saturation zones and the exact-limit edge occur within a few hundred clocks. An 8-bit compare value already covers values above the limit. Several compare values, including twice the dead time, are run with flipped polarities and cleared enables. This shows that the pin mapping and the gating leave the underlying states untouched.

// File: rtl/comp_phase_out.sv
module comp_phase_out #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_a,
  input  logic [W-1:0] cnt_b,
  input  logic         a_down,
  input  logic         b_down,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] upper_lim,
  input  logic         pol_pos,
  input  logic         pol_neg,
  input  logic         oe_pos,
  input  logic         oe_neg,
  output logic         pos_out,
  output logic         neg_out
);

  logic pos_act, neg_act;
  logic zero_sat, top_sat, live, a_hit, b_hit;

  assign zero_sat = (cmp_val == '0);
  assign top_sat  = !zero_sat && (cmp_val >= upper_lim);
  assign live     = !zero_sat && !top_sat;
  assign a_hit    = live && (cnt_a == cmp_val);
  assign b_hit    = live && (cnt_b == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_act <= 1'b0;
      neg_act <= 1'b0;
    end else if (zero_sat) begin
      pos_act <= 1'b1;
      neg_act <= 1'b0;
    end else if (top_sat) begin
      pos_act <= 1'b0;
      neg_act <= 1'b1;
    end else begin
      if (a_hit) neg_act <= a_down;
      if (b_hit) pos_act <= !b_down;
    end
  end

  assign pos_out = (oe_pos && pos_act) ? pol_pos : !pol_pos;
  assign neg_out = (oe_neg && neg_act) ? pol_neg : !pol_neg;

  p_a_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_val != '0 && cmp_val < upper_lim && cnt_a == cmp_val && !a_down) |=> !neg_act);
  p_b_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_val != '0 && cmp_val < upper_lim && cnt_b == cmp_val && !b_down) |=> pos_act);
  p_a_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_val != '0 && cmp_val < upper_lim && cnt_a == cmp_val && a_down) |=> neg_act);
  p_b_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_val != '0 && cmp_val < upper_lim && cnt_b == cmp_val && b_down) |=> !pos_act);
  p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_val == '0) |=> (pos_act && !neg_act));
  p_top_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_val != '0 && cmp_val >= upper_lim) |=> (!pos_act && neg_act));
  p_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_val != '0 && cmp_val < upper_lim && cnt_a != cmp_val) |=> $stable(neg_act));
  p_hold_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_val != '0 && cmp_val < upper_lim && cnt_b != cmp_val) |=> $stable(pos_act));

  always_comb begin
    if (rst_n && !oe_pos) p_gate_pos_r9: assert (pos_out == !pol_pos);
    if (rst_n && !oe_neg) p_gate_neg_r9: assert (neg_out == !pol_neg);
  end

endmodule

// File: tb/comp_phase_out_tb.sv
module comp_phase_out_tb;
  localparam int W = 8;
  localparam int HALF = 20;
  localparam int DT = 3;
  localparam int UPPER = HALF + DT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] cnt_a = '0, cnt_b = '0, cmp_val = '0, upper_lim = UPPER[W-1:0];
  logic a_down = 1'b0, b_down = 1'b0;
  logic pol_pos = 1'b0, pol_neg = 1'b0, oe_pos = 1'b1, oe_neg = 1'b1;
  logic pos_out, neg_out;

  int checks = 0, failures = 0, cyc = 0;
  int m_pos = 0, m_neg = 0;
  int prev_pos = 1, prev_neg = 1, t_neg_off = -1;
  bit gap_on = 0;
  string tag = "R8";

  always #4 clk = ~clk;

  comp_phase_out #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .a_down(a_down), .b_down(b_down), .cmp_val(cmp_val), .upper_lim(upper_lim),
    .pol_pos(pol_pos), .pol_neg(pol_neg), .oe_pos(oe_pos), .oe_neg(oe_neg),
    .pos_out(pos_out), .neg_out(neg_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    int c, a, b, ep, en;
    @(posedge clk);
    c = int'(cmp_val); a = int'(cnt_a); b = int'(cnt_b);
    if (c == 0) begin m_pos = 1; m_neg = 0; end
    else if (c >= int'(upper_lim)) begin m_pos = 0; m_neg = 1; end
    else begin
      if (a == c) m_neg = a_down ? 1 : 0;
      if (b == c) m_pos = b_down ? 0 : 1;
    end
    @(negedge clk);
    cyc++;
    ep = (oe_pos && m_pos != 0) ? int'(pol_pos) : int'(!pol_pos);
    en = (oe_neg && m_neg != 0) ? int'(pol_neg) : int'(!pol_neg);
    check({tag, " pos"}, int'(pos_out), ep);
    check({tag, " neg"}, int'(neg_out), en);
    if (gap_on) begin
      check("R10 overlap", int'(!pos_out && !neg_out), 0);
      if (neg_out && prev_neg == 0) t_neg_off = cyc;
      if (!pos_out && prev_pos == 1 && t_neg_off >= 0)
        check("R10 dead gap", cyc - t_neg_off, DT);
    end
    prev_pos = int'(pos_out); prev_neg = int'(neg_out);
  endtask

  task automatic run(input int cv, input bit pp, input bit pn, input bit ep,
                     input bit en, input string t, input bit gap);
    cmp_val = cv[W-1:0]; pol_pos = pp; pol_neg = pn; oe_pos = ep; oe_neg = en;
    tag = t; gap_on = gap; t_neg_off = -1;
    for (int i = 0; i < 4 * HALF; i++) begin
      int k, bv;
      k = i % (2 * HALF);
      bv = (k <= HALF) ? k : 2 * HALF - k;
      cnt_b = bv[W-1:0];
      cnt_a = 8'(bv + DT);
      b_down = (k > HALF);
      a_down = (k > HALF);
      step();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset pos", int'(pos_out), 1);
    check("R8 reset neg", int'(neg_out), 1);
    cmp_val = 8'd10;
    rst_n = 1'b1;
    run(10, 0, 0, 1, 1, "R1 R2 R3 R4 R7", 1);
    run(2 * DT, 0, 0, 1, 1, "R1 R2 R3 R4 twice-dead", 1);
    run(19, 0, 0, 1, 1, "R7 near-limit", 1);
    run(0, 0, 0, 1, 1, "R5 zero", 0);
    run(UPPER, 0, 0, 1, 1, "R6 at limit", 0);
    run(30, 0, 0, 1, 1, "R6 above limit", 0);
    run(10, 1, 1, 1, 1, "R8 active-high", 0);
    run(10, 1, 0, 1, 1, "R8 mixed polarity", 0);
    run(10, 0, 0, 0, 1, "R9 pos gated", 0);
    run(10, 0, 0, 1, 0, "R9 neg gated", 0);
    run(0, 1, 0, 0, 0, "R9 both gated", 0);
    run(10, 0, 0, 1, 1, "R9 state after gating", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule